// File: doc/BRIEF.md
# Ping-Pong Frame Buffer Controller

This block runs two equal sample banks in alternation. One bank takes the acquisition write stream while the other is read out by a drain-side consumer. When the fill bank holds a programmed number of complete multichannel frames, the two banks trade roles. A frame is one sample for each active channel. The frame count and the active-channel count are captured only when the converter reset is pulsed, so register writes made between resets have no effect on the running stream.

The drain side sees `ready_o` while a completed bank still holds unread words. It pulls words one at a time with `rd_req_i`, and each word comes back on the following cycle. A bank that completes while the other bank is still being drained is held back. Writes that arrive during that hold are dropped and raise a sticky overrun flag. The held bank is handed over on the cycle after the drain empties.

Top module: `pingpong_frame_buf`

## Requirements
- R1: After any reset, bank 0 is the fill bank. Each swap toggles `fill_sel_o`, and `drain_sel_o` then names the bank that has just been filled. While `ready_o` is high the two selects differ.
- R2: With the drain empty, the write accepted on edge E that completes the N-th frame makes `ready_o` high and toggles `fill_sel_o` on edge E+1. Fewer words leave `ready_o` low.
- R3: A frame is C words, where C is the channel count latched at converter reset. A latched value of 0 is used as 1, and values above MAX_CH are used as MAX_CH.
- R4: N is the 8-bit frame count latched at converter reset, valid from 1 to 255. A latched value of 0 is used as 1.
- R5: A change of `frame_cnt_i` or `chan_cnt_i` without a converter reset does not change the number of words per bank.
- R6: A cycle with `cnv_rst_i` high empties both banks, clears the word and frame counters, clears `overrun_o`, and makes bank 0 the fill bank as from the next edge.
- R7: When the fill bank is complete and the drain bank is not empty, writes are not stored (`buf_we_o` low), `overrun_o` goes high on the next edge and stays high until a reset, and the held bank is swapped in one edge after the drain empties. Dropped words never appear at the output.
- R8: A read request is accepted only while `ready_o` is high (`buf_re_o` high in that cycle). The word appears on `rd_data_o` with `rd_valid_o` on the next cycle, in write order. `rd_last_o` marks the final word of the bank. A request made while `ready_o` is low yields no `rd_valid_o`.
- R9: `ready_o` stays high until the last word of the bank has been accepted, and it is low on the cycle after that.
- R10: When the drain keeps pace with the fill, no word is lost, `overrun_o` stays low, and the output stream equals the input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnv_rst_i | input | 1 | Converter reset; latches the counts and empties both banks |
| frame_cnt_i | input | FCNT_W | Frames per bank (0 is used as 1) |
| chan_cnt_i | input | CH_W | Active channel count (0 is used as 1) |
| wr_valid_i | input | 1 | Acquisition sample valid |
| wr_data_i | input | DATA_W | Acquisition sample |
| rd_req_i | input | 1 | Drain-side word request |
| fill_sel_o | output | 1 | Bank currently filling |
| drain_sel_o | output | 1 | Bank currently draining |
| buf_we_o | output | 1 | Sample stored this cycle |
| buf_re_o | output | 1 | Read request accepted this cycle |
| ready_o | output | 1 | Drain bank holds unread words |
| overrun_o | output | 1 | Sticky; a sample was dropped |
| rd_valid_o | output | 1 | rd_data_o is valid |
| rd_data_o | output | DATA_W | Drained sample |
| rd_last_o | output | 1 | Final word of the drained bank |

## Verification
On every cycle, the assertions check that a held bank stays held while the drain is busy, and that a dropped write raises the overrun flag. They also check that a swap always produces `ready_o`, that `ready_o` does not fall before the last word is read, that every accepted read yields valid data on the next cycle, and that the converter reset clears the outputs it should. Other properties can only be shown by the bench's scenarios: the exact count of words that completes a bank, the substitution of zero counts, the fact that the register inputs are ignored without a converter reset, and data order and content across swaps. The same holds for the absence of dropped words in the output after an overrun.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_MAX_CH = 4;
  localparam int unsigned DEF_FCNT_W = 8;

  // read-side status carried with each drained word
  typedef struct packed {
    logic valid;
    logic last;
  } pfb_rd_stat_t;
endpackage

// File: rtl/pfb_bank_mem.sv
module pfb_bank_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 1020,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              wsel_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic              rsel_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] bank_q [2];
  logic              rsel_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (wsel_i == 1'(b))) mem[waddr_i] <= wdata_i;
      if (re_i && (rsel_i == 1'(b))) bank_q[b] <= mem[raddr_i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (re_i) rsel_q <= rsel_i;
  end

  assign rdata_o = bank_q[rsel_q];
endmodule

// File: rtl/pfb_fill_ctrl.sv
module pfb_fill_ctrl #(
  parameter int unsigned FCNT_W = 8,
  parameter int unsigned MAX_CH = 4,
  parameter int unsigned CH_W   = $clog2(MAX_CH + 1),
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_rst_i,
  input  logic [FCNT_W-1:0] frame_cnt_i,
  input  logic [CH_W-1:0]   chan_cnt_i,
  input  logic              wr_valid_i,
  input  logic              drain_empty_i,
  output logic              we_o,
  output logic              wsel_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              swap_o,
  output logic              swap_sel_o,
  output logic [CNT_W-1:0]  swap_words_o,
  output logic              fill_sel_o,
  output logic              overrun_o
);
  logic [FCNT_W-1:0] n_q, frm_q, base_frm;
  logic [CH_W-1:0]   ch_q, chi_q, base_ch, ch_eff;
  logic [CNT_W-1:0]  wptr_q, base_ptr;
  logic              full_q, sel_q, ovr_q;
  logic              open_w, last_ch, last_frm, done_w;
  logic [FCNT_W-1:0] n_eff;

  // zero means one; channel count saturates at MAX_CH
  always_comb begin
    n_eff = (frame_cnt_i == '0) ? FCNT_W'(1) : frame_cnt_i;
    if (chan_cnt_i == '0)                   ch_eff = CH_W'(1);
    else if (chan_cnt_i > CH_W'(MAX_CH))    ch_eff = CH_W'(MAX_CH);
    else                                    ch_eff = chan_cnt_i;
  end

  always_comb begin
    swap_o   = full_q & drain_empty_i & ~cnv_rst_i;
    open_w   = ~full_q | drain_empty_i;
    we_o     = wr_valid_i & open_w & ~cnv_rst_i;
    // a write in the swap cycle starts the freshly freed bank
    base_ptr = full_q ? '0 : wptr_q;
    base_ch  = full_q ? '0 : chi_q;
    base_frm = full_q ? '0 : frm_q;
    wsel_o   = sel_q ^ full_q;
    waddr_o  = base_ptr[ADDR_W-1:0];
    last_ch  = (base_ch == ch_q - CH_W'(1));
    last_frm = (base_frm == n_q - FCNT_W'(1));
    done_w   = we_o & last_ch & last_frm;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q    <= FCNT_W'(1);
      ch_q   <= CH_W'(1);
      frm_q  <= '0;
      chi_q  <= '0;
      wptr_q <= '0;
      full_q <= 1'b0;
      sel_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (cnv_rst_i) begin
      n_q    <= n_eff;
      ch_q   <= ch_eff;
      frm_q  <= '0;
      chi_q  <= '0;
      wptr_q <= '0;
      full_q <= 1'b0;
      sel_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (swap_o) sel_q <= ~sel_q;
      if (wr_valid_i && !open_w) ovr_q <= 1'b1;
      if (we_o) begin
        wptr_q <= base_ptr + CNT_W'(1);
        chi_q  <= last_ch ? '0 : base_ch + CH_W'(1);
        frm_q  <= last_ch ? base_frm + FCNT_W'(1) : base_frm;
        full_q <= done_w;
      end else if (swap_o) begin
        wptr_q <= '0;
        chi_q  <= '0;
        frm_q  <= '0;
        full_q <= 1'b0;
      end
    end
  end

  assign swap_sel_o   = sel_q;
  assign swap_words_o = wptr_q;
  assign fill_sel_o   = sel_q;
  assign overrun_o    = ovr_q;

  // R7
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !cnv_rst_i && full_q && !drain_empty_i) |=> overrun_o);

  // R7
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !drain_empty_i && !cnv_rst_i) |=> (full_q && $stable(sel_q)));

  // R3
  ch_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chi_q < ch_q));
endmodule

// File: rtl/pfb_drain_ctrl.sv
module pfb_drain_ctrl #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned ADDR_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cnv_rst_i,
  input  logic                 swap_i,
  input  logic                 swap_sel_i,
  input  logic [CNT_W-1:0]     swap_words_i,
  input  logic                 rd_req_i,
  output logic                 re_o,
  output logic                 rsel_o,
  output logic [ADDR_W-1:0]    raddr_o,
  output logic                 ready_o,
  output logic                 drain_empty_o,
  output pfb_pkg::pfb_rd_stat_t stat_o
);
  logic [CNT_W-1:0] left_q, rptr_q;
  logic             dsel_q, last_w;
  pfb_pkg::pfb_rd_stat_t stat_q;

  always_comb begin
    ready_o       = (left_q != '0);
    drain_empty_o = ~ready_o;
    re_o          = rd_req_i & ready_o & ~cnv_rst_i;
    last_w        = (left_q == CNT_W'(1));
    raddr_o       = rptr_q[ADDR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      rptr_q <= '0;
      dsel_q <= 1'b1;
      stat_q <= '0;
    end else if (cnv_rst_i) begin
      left_q <= '0;
      rptr_q <= '0;
      dsel_q <= 1'b1;
      stat_q <= '0;
    end else begin
      stat_q.valid <= re_o;
      stat_q.last  <= re_o & last_w;
      if (swap_i) begin
        left_q <= swap_words_i;
        rptr_q <= '0;
        dsel_q <= swap_sel_i;
      end else if (re_o) begin
        left_q <= left_q - CNT_W'(1);
        rptr_q <= rptr_q + CNT_W'(1);
      end
    end
  end

  assign rsel_o = dsel_q;
  assign stat_o = stat_q;

  // R8
  rd_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_o && !cnv_rst_i) |=> stat_o.valid);

  // R9
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !cnv_rst_i && !(re_o && last_w)) |=> ready_o);

  // R9
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_o && last_w && !cnv_rst_i) |=> !ready_o);
endmodule

// File: rtl/pingpong_frame_buf.sv
module pingpong_frame_buf #(
  parameter int unsigned DATA_W = pfb_pkg::DEF_DATA_W,
  parameter int unsigned MAX_CH = pfb_pkg::DEF_MAX_CH,
  parameter int unsigned FCNT_W = pfb_pkg::DEF_FCNT_W,
  parameter int unsigned CH_W   = $clog2(MAX_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_rst_i,
  input  logic [FCNT_W-1:0] frame_cnt_i,
  input  logic [CH_W-1:0]   chan_cnt_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  output logic              fill_sel_o,
  output logic              drain_sel_o,
  output logic              buf_we_o,
  output logic              buf_re_o,
  output logic              ready_o,
  output logic              overrun_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o
);
  localparam int unsigned MAX_FRM = (1 << FCNT_W) - 1;
  localparam int unsigned DEPTH   = MAX_FRM * MAX_CH;
  localparam int unsigned ADDR_W  = $clog2(DEPTH);
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1);

  logic              we_w, wsel_w, swap_w, swap_sel_w, re_w, rsel_w, empty_w;
  logic [ADDR_W-1:0] waddr_w, raddr_w;
  logic [CNT_W-1:0]  swap_words_w;
  pfb_pkg::pfb_rd_stat_t stat_w;

  pfb_fill_ctrl #(
    .FCNT_W(FCNT_W), .MAX_CH(MAX_CH), .CH_W(CH_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_fill (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnv_rst_i    (cnv_rst_i),
    .frame_cnt_i  (frame_cnt_i),
    .chan_cnt_i   (chan_cnt_i),
    .wr_valid_i   (wr_valid_i),
    .drain_empty_i(empty_w),
    .we_o         (we_w),
    .wsel_o       (wsel_w),
    .waddr_o      (waddr_w),
    .swap_o       (swap_w),
    .swap_sel_o   (swap_sel_w),
    .swap_words_o (swap_words_w),
    .fill_sel_o   (fill_sel_o),
    .overrun_o    (overrun_o)
  );

  pfb_drain_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_drain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnv_rst_i    (cnv_rst_i),
    .swap_i       (swap_w),
    .swap_sel_i   (swap_sel_w),
    .swap_words_i (swap_words_w),
    .rd_req_i     (rd_req_i),
    .re_o         (re_w),
    .rsel_o       (rsel_w),
    .raddr_o      (raddr_w),
    .ready_o      (ready_o),
    .drain_empty_o(empty_w),
    .stat_o       (stat_w)
  );

  pfb_bank_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (we_w),
    .wsel_i (wsel_w),
    .waddr_i(waddr_w),
    .wdata_i(wr_data_i),
    .re_i   (re_w),
    .rsel_i (rsel_w),
    .raddr_i(raddr_w),
    .rdata_o(rd_data_o)
  );

  assign drain_sel_o = rsel_w;
  assign buf_we_o    = we_w;
  assign buf_re_o    = re_w;
  assign rd_valid_o  = stat_w.valid;
  assign rd_last_o   = stat_w.last;

  // R1
  sel_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (drain_sel_o != fill_sel_o));

  // R6
  cnv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_rst_i |=> (!ready_o && !overrun_o && !fill_sel_o));

  // R2
  swap_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_w |=> (ready_o && (fill_sel_o != $past(fill_sel_o))));
endmodule

// File: tb/pingpong_frame_buf_test.sv
`timescale 1ns/1ps
module pingpong_frame_buf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnv_rst = 1'b0;
  logic [7:0]  frame_cnt = 8'd1;
  logic [2:0]  chan_cnt = 3'd1;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic        fill_sel, drain_sel, buf_we, buf_re, ready, overrun;
  logic        rd_valid, rd_last;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;
  bit fin = 1'b0;
  int exp_mem [4096];

  always #2 clk = ~clk;

  pingpong_frame_buf uut (
    .clk_i(clk), .rst_ni(rst_n), .cnv_rst_i(cnv_rst), .frame_cnt_i(frame_cnt),
    .chan_cnt_i(chan_cnt), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_req_i(rd_req), .fill_sel_o(fill_sel), .drain_sel_o(drain_sel),
    .buf_we_o(buf_we), .buf_re_o(buf_re), .ready_o(ready), .overrun_o(overrun),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_last_o(rd_last)
  );

  function automatic int eff_frames(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int eff_chans(input int v);
    return (v == 0) ? 1 : ((v > 4) ? 4 : v);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cnv_reset(input int n, input int c);
    frame_cnt = 8'(n);
    chan_cnt  = 3'(c);
    cnv_rst   = 1'b1;
    @(negedge clk);
    cnv_rst   = 1'b0;
  endtask

  task automatic put(input int d);
    wr_valid = 1'b1;
    wr_data  = 16'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic take(input int exp, input bit exp_last, input string req);
    rd_req = 1'b1;
    #1 chk(buf_re == 1'b1, req, int'(buf_re), 1);
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_valid == 1'b1, req, int'(rd_valid), 1);
    chk(int'(rd_data) == exp, req, int'(rd_data), exp);
    chk(rd_last == exp_last, req, int'(rd_last), int'(exp_last));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 / R1: state after reset
    chk(ready == 1'b0, "R6", int'(ready), 0);
    chk(fill_sel == 1'b0, "R1", int'(fill_sel), 0);
    chk(overrun == 1'b0, "R6", int'(overrun), 0);
    chk(rd_valid == 1'b0, "R8", int'(rd_valid), 0);

    // N=2, C=3: six words per bank
    cnv_reset(2, 3);
    chk(fill_sel == 1'b0 && ready == 1'b0, "R6", int'(fill_sel), 0);
    for (int i = 0; i < 5; i++) put(100 + i);
    chk(ready == 1'b0, "R2", int'(ready), 0);
    frame_cnt = 8'd5;  // R5: no converter reset follows
    put(105);
    chk(ready == 1'b0, "R2", int'(ready), 0);
    @(negedge clk);
    chk(ready == 1'b1, "R2", int'(ready), 1);
    chk(fill_sel == 1'b1 && drain_sel == 1'b0, "R1", int'(fill_sel), 1);
    // fill bank 1 while bank 0 waits: still 6 words per bank (R5)
    for (int i = 0; i < 6; i++) put(200 + i);
    repeat (2) @(negedge clk);
    chk(fill_sel == 1'b1, "R5", int'(fill_sel), 1);
    chk(overrun == 1'b0, "R7", int'(overrun), 0);
    // extra writes are dropped
    wr_valid = 1'b1;
    wr_data  = 16'd300;
    #1 chk(buf_we == 1'b0, "R7", int'(buf_we), 0);
    @(negedge clk);
    wr_data = 16'd301;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(overrun == 1'b1, "R7", int'(overrun), 1);
    for (int i = 0; i < 6; i++) take(100 + i, i == 5, "R8");
    chk(ready == 1'b0, "R9", int'(ready), 0);
    @(negedge clk);
    chk(ready == 1'b1 && fill_sel == 1'b0, "R7", int'(ready), 1);
    for (int i = 0; i < 6; i++) take(200 + i, i == 5, "R7");
    chk(ready == 1'b0, "R9", int'(ready), 0);
    chk(overrun == 1'b1, "R7", int'(overrun), 1);
    // request while not ready is ignored
    rd_req = 1'b1;
    #1 chk(buf_re == 1'b0, "R8", int'(buf_re), 0);
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_valid == 1'b0, "R8", int'(rd_valid), 0);

    // R4: frame count 0 behaves as 1
    cnv_reset(0, 2);
    chk(overrun == 1'b0, "R6", int'(overrun), 0);
    put(7);
    put(8);
    @(negedge clk);
    chk(ready == 1'b1, "R4", int'(ready), 1);
    // R6: converter reset with a ready bank
    cnv_reset(1, 0);
    chk(ready == 1'b0 && fill_sel == 1'b0, "R6", int'(ready), 0);
    // R3: channel count 0 behaves as 1
    put(9);
    @(negedge clk);
    chk(ready == 1'b1, "R3", int'(ready), 1);
    take(9, 1'b1, "R3");
    // R3: channel count above maximum saturates to 4
    cnv_reset(1, 7);
    for (int i = 0; i < 3; i++) put(i);
    @(negedge clk);
    chk(ready == 1'b0, "R3", int'(ready), 0);
    put(3);
    @(negedge clk);
    chk(ready == 1'b1, "R3", int'(ready), 1);
    // R4: maximum frame count 255
    cnv_reset(255, 1);
    for (int i = 0; i < 254; i++) put(i);
    @(negedge clk);
    chk(ready == 1'b0, "R4", int'(ready), 0);
    put(254);
    @(negedge clk);
    chk(ready == 1'b1, "R4", int'(ready), 1);
    take(0, 1'b0, "R4");

    // R10: random streams, drain keeps pace
    for (int cfg = 0; cfg < 5; cfg++) begin
      int n_raw, c_raw, w, nbuf, wr_tot, rd_tot, bw, idle;
      bit acc_prev;
      n_raw = $urandom_range(0, 6);
      c_raw = $urandom_range(0, 4);
      w     = eff_frames(n_raw) * eff_chans(c_raw);
      nbuf  = 12;
      wr_tot = 0; rd_tot = 0; bw = 0; idle = 0; acc_prev = 1'b0;
      cnv_reset(n_raw, c_raw);
      while (rd_tot < w * nbuf) begin
        if (rd_valid != acc_prev) chk(1'b0, "R8", int'(rd_valid), int'(acc_prev));
        if (rd_valid) begin
          chk(int'(rd_data) == exp_mem[rd_tot], "R10", int'(rd_data), exp_mem[rd_tot]);
          chk(rd_last == (((rd_tot + 1) % w) == 0), "R8", int'(rd_last),
              int'(((rd_tot + 1) % w) == 0));
          rd_tot++;
        end
        wr_valid = 1'b0;
        if (bw == w) begin
          if (rd_tot >= wr_tot - w) begin
            idle++;
            if (idle >= 2) begin
              bw = 0;
              idle = 0;
            end
          end
        end else if (wr_tot < w * nbuf && $urandom_range(0, 9) < 7) begin
          exp_mem[wr_tot] = int'($urandom_range(0, 65535));
          wr_data  = 16'(exp_mem[wr_tot]);
          wr_valid = 1'b1;
          wr_tot++;
          bw++;
        end
        rd_req   = ($urandom_range(0, 9) < 6);
        acc_prev = rd_req && ready;
        @(negedge clk);
      end
      wr_valid = 1'b0;
      rd_req   = 1'b0;
      @(negedge clk);
      chk(overrun == 1'b0, "R10", int'(overrun), 0);
      chk(ready == 1'b0, "R9", int'(ready), 0);
    end

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule